// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sits between a processor core and the clock gates, oscillator enables and core-domain power switch of a small microcontroller. When the core reports that it has executed a wait-for-interrupt or wait-for-event instruction, the controller reads the sleep control bits and chooses one of three low-power modes. Light sleep stops only the CPU clock. Deep sleep stops every core-domain clock and switches off the internal RC oscillator, the crystal oscillator and the PLL. Standby also removes power from the core domain.

While the block is in a low-power mode, it accepts only the wakeup sources that are legal for that mode. After a wake, it restores power and clocks step by step. Each analog resource is modelled as an enable output paired with a ready input. When the run state is reached again, the block issues a one-cycle wake pulse. A wake from standby also raises a power-on flag, because the core must then boot from the start and cannot resume. All pins are plain level control and status signals. No stream interface exists, so no back-pressure rules apply.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the block is in run mode: `cur_mode` is 0, all five enables and `core_pwr_en` are 1, and `reg_lowpwr`, `wake_pulse` and `por_pulse` are 0.
- R2: An `entry_vld` strobe in run mode with `ctl_deep`=0 enters light sleep (`cur_mode`=1) on the following cycle. Only `cpu_clk_en` drops.
- R3: An `entry_vld` strobe with `ctl_deep`=1 enters deep sleep (`cur_mode`=2) unless both `ctl_stby` and `ctl_wkrst` are 1. In deep sleep, `cpu_clk_en`, `core_clk_en`, `irc_en`, `xtal_en` and `pll_en` are 0. `reg_lowpwr` equals `ctl_reglp` as sampled at entry.
- R4: An `entry_vld` strobe with `ctl_deep`, `ctl_stby` and `ctl_wkrst` all 1 enters standby (`cur_mode`=3). In standby every enable, including `core_pwr_en`, is 0.
- R5: The control bits, `entry_wfe` and `ctl_sevonpend` are captured on the `entry_vld` cycle. Changing them later alters neither the mode nor its wake rule, and `cur_mode` holds its value until run is reached again.
- R6: In light sleep entered with `entry_wfe`=0, only `irq_any` wakes the block. With `entry_wfe`=1, `evt_any` wakes it, and `irq_any` also wakes it when the captured `ctl_sevonpend` is 1. The block returns to run on the next cycle.
- R7: Deep sleep follows the same wait-for-interrupt/wait-for-event rule as light sleep, but only over the external line vectors `exti_irq` and `exti_evt`. `irq_any` and `evt_any` are ignored.
- R8: Standby ignores `irq_any`, `evt_any` and the external lines. It is left only on a high `wkup_pin` bit, `wdog_rst` or `rtc_alarm`.
- R9: A deep-sleep wake restores resources in this order. If `reg_lowpwr` was set, the block first clears it and waits for `reg_rdy`. It then enables the RC oscillator and waits for `irc_rdy`, then enables the crystal and waits for `xtal_rdy`. It then waits `XTAL_SETTLE` further cycles before enabling the PLL and waiting for `pll_rdy`. The core clocks return only after all of these steps.
- R10: A standby wake first raises `core_pwr_en` and waits for `pwr_good`, then runs the oscillator chain of R9. On reaching run, `por_pulse` is raised together with `wake_pulse`.
- R11: `entry_vld` is ignored in every state other than run.
- R12: `wake_pulse` is high for exactly the first cycle back in run after any low-power mode, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_vld | input | 1 | Core executed a wait instruction |
| entry_wfe | input | 1 | 1 = wait-for-event, 0 = wait-for-interrupt |
| ctl_deep | input | 1 | Deep low-power request bit |
| ctl_stby | input | 1 | Standby select bit |
| ctl_wkrst | input | 1 | Wakeup-reset flag that must be set for standby |
| ctl_sevonpend | input | 1 | Pending interrupt counts as an event |
| ctl_reglp | input | 1 | Regulator goes low-power in deep sleep |
| irq_any | input | 1 | Any interrupt pending |
| evt_any | input | 1 | Any event |
| exti_irq | input | NEXTI | External-line interrupts |
| exti_evt | input | NEXTI | External-line events |
| wkup_pin | input | NWKUP | Standby wakeup pins |
| wdog_rst | input | 1 | Watchdog reset request |
| rtc_alarm | input | 1 | RTC alarm |
| reg_rdy | input | 1 | Regulator back at full drive |
| pwr_good | input | 1 | Core-domain supply valid |
| irc_rdy | input | 1 | RC oscillator ready |
| xtal_rdy | input | 1 | Crystal oscillator ready |
| pll_rdy | input | 1 | PLL locked |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| core_clk_en | output | 1 | Core-domain clock gate enable |
| irc_en | output | 1 | RC oscillator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| core_pwr_en | output | 1 | Core-domain power switch |
| reg_lowpwr | output | 1 | Regulator low-power request |
| wake_pulse | output | 1 | One-cycle wake indication |
| por_pulse | output | 1 | Wake came from standby; full boot needed |
| cur_mode | output | 2 | 0 run, 1 sleep, 2 deep sleep, 3 standby |

## Verification
The bench targets the cases where one mode's wake rule could leak into another. It sends an event during wait-for-interrupt sleep, which a design that ORs every source would wrongly accept. It raises a core interrupt during deep sleep, which a design that does not gate sources by mode would wrongly wake on. It sends external-line activity during standby, which must also be ignored. It rewrites the control bits after entry and strobes `entry_vld` during sleep. A design that reads the bits live, or that re-enters on a second strobe, changes mode partway through. It also enters with `ctl_stby` set and `ctl_wkrst` clear. A wrongly decoding design would power down the core instead of entering deep sleep. Every restore step is compared cycle by cycle against a queue-based model. An enable that rises early, a skipped regulator step or an off-by-one crystal settle count therefore appears at the cycle where it occurs.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_DEEP  = 2'd2,
    MODE_STBY  = 2'd3
  } lpm_mode_e;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_SLEEP,
    ST_DEEP,
    ST_STBY,
    ST_REG,
    ST_PWR,
    ST_IRC,
    ST_XTAL,
    ST_XSET,
    ST_PLL
  } lpm_state_e;

  typedef struct packed {
    logic cpu_clk;
    logic core_clk;
    logic irc;
    logic xtal;
    logic pll;
    logic pwr;
    logic reg_lp;
  } lpm_gates_t;

endpackage

// File: rtl/lpm_mode_dec.sv
module lpm_mode_dec
  import lpm_pkg::*;
(
  input  logic      deep,
  input  logic      stby,
  input  logic      wkrst,
  output lpm_mode_e mode
);
  always_comb begin
    if (!deep)               mode = MODE_SLEEP;
    else if (stby && wkrst)  mode = MODE_STBY;
    else                     mode = MODE_DEEP;
  end
endmodule

// File: rtl/lpm_wake_eval.sv
module lpm_wake_eval
  import lpm_pkg::*;
#(
  parameter int NEXTI = 4,
  parameter int NWKUP = 2
) (
  input  lpm_mode_e        mode,
  input  logic             wfe,
  input  logic             sev,
  input  logic             irq_any,
  input  logic             evt_any,
  input  logic [NEXTI-1:0] exti_irq,
  input  logic [NEXTI-1:0] exti_evt,
  input  logic [NWKUP-1:0] wkup_pin,
  input  logic             wdog_rst,
  input  logic             rtc_alarm,
  output logic             wake
);
  logic line_irq, line_evt, core_hit, line_hit, stby_hit;

  assign line_irq = |exti_irq;
  assign line_evt = |exti_evt;

  // wait-for-event accepts events, plus interrupts when sev is set
  assign core_hit = wfe ? (evt_any  | (sev & irq_any))  : irq_any;
  assign line_hit = wfe ? (line_evt | (sev & line_irq)) : line_irq;
  assign stby_hit = (|wkup_pin) | wdog_rst | rtc_alarm;

  always_comb begin
    unique case (mode)
      MODE_SLEEP: wake = core_hit;
      MODE_DEEP:  wake = line_hit;
      MODE_STBY:  wake = stby_hit;
      default:    wake = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpm_gate_dec.sv
module lpm_gate_dec
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  input  logic       lp_sel,
  output lpm_gates_t gates
);
  always_comb begin
    gates = '0;
    unique case (state)
      ST_RUN:   gates = '{cpu_clk:1'b1, core_clk:1'b1, irc:1'b1, xtal:1'b1,
                          pll:1'b1, pwr:1'b1, reg_lp:1'b0};
      ST_SLEEP: gates = '{cpu_clk:1'b0, core_clk:1'b1, irc:1'b1, xtal:1'b1,
                          pll:1'b1, pwr:1'b1, reg_lp:1'b0};
      ST_DEEP: begin
        gates.pwr    = 1'b1;
        gates.reg_lp = lp_sel;
      end
      ST_STBY:  gates = '0;
      ST_PWR, ST_REG: gates.pwr = 1'b1;
      ST_IRC: begin
        gates.pwr = 1'b1;
        gates.irc = 1'b1;
      end
      ST_XTAL, ST_XSET: begin
        gates.pwr  = 1'b1;
        gates.irc  = 1'b1;
        gates.xtal = 1'b1;
      end
      ST_PLL: begin
        gates.pwr  = 1'b1;
        gates.irc  = 1'b1;
        gates.xtal = 1'b1;
        gates.pll  = 1'b1;
      end
      default: gates = '0;
    endcase
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NEXTI       = 4,
  parameter int NWKUP       = 2,
  parameter int XTAL_SETTLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry_vld,
  input  logic             entry_wfe,
  input  logic             ctl_deep,
  input  logic             ctl_stby,
  input  logic             ctl_wkrst,
  input  logic             ctl_sevonpend,
  input  logic             ctl_reglp,
  input  logic             irq_any,
  input  logic             evt_any,
  input  logic [NEXTI-1:0] exti_irq,
  input  logic [NEXTI-1:0] exti_evt,
  input  logic [NWKUP-1:0] wkup_pin,
  input  logic             wdog_rst,
  input  logic             rtc_alarm,
  input  logic             reg_rdy,
  input  logic             pwr_good,
  input  logic             irc_rdy,
  input  logic             xtal_rdy,
  input  logic             pll_rdy,
  output logic             cpu_clk_en,
  output logic             core_clk_en,
  output logic             irc_en,
  output logic             xtal_en,
  output logic             pll_en,
  output logic             core_pwr_en,
  output logic             reg_lowpwr,
  output logic             wake_pulse,
  output logic             por_pulse,
  output logic [1:0]       cur_mode
);
  localparam int SETTLE = (XTAL_SETTLE < 1) ? 1 : XTAL_SETTLE;
  localparam int CW     = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE - 1);

  lpm_state_e    state_q, state_d;
  lpm_mode_e     mode_q, mode_d, entry_mode;
  logic          wfe_q, sev_q, lp_q;
  logic [CW-1:0] cnt_q;
  logic          wake_q, por_q, wake_hit;
  lpm_gates_t    gates;

  lpm_mode_dec u_dec (
    .deep  (ctl_deep),
    .stby  (ctl_stby),
    .wkrst (ctl_wkrst),
    .mode  (entry_mode)
  );

  lpm_wake_eval #(.NEXTI(NEXTI), .NWKUP(NWKUP)) u_wake (
    .mode      (mode_q),
    .wfe       (wfe_q),
    .sev       (sev_q),
    .irq_any   (irq_any),
    .evt_any   (evt_any),
    .exti_irq  (exti_irq),
    .exti_evt  (exti_evt),
    .wkup_pin  (wkup_pin),
    .wdog_rst  (wdog_rst),
    .rtc_alarm (rtc_alarm),
    .wake      (wake_hit)
  );

  lpm_gate_dec u_gate (
    .state  (state_q),
    .lp_sel (lp_q),
    .gates  (gates)
  );

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    unique case (state_q)
      ST_RUN: if (entry_vld) begin
        mode_d = entry_mode;
        unique case (entry_mode)
          MODE_SLEEP: state_d = ST_SLEEP;
          MODE_DEEP:  state_d = ST_DEEP;
          MODE_STBY:  state_d = ST_STBY;
          default:    state_d = ST_RUN;
        endcase
      end
      ST_SLEEP: if (wake_hit) state_d = ST_RUN;
      ST_DEEP:  if (wake_hit) state_d = lp_q ? ST_REG : ST_IRC;
      ST_STBY:  if (wake_hit) state_d = ST_PWR;
      ST_REG:   if (reg_rdy)  state_d = ST_IRC;
      ST_PWR:   if (pwr_good) state_d = ST_IRC;
      ST_IRC:   if (irc_rdy)  state_d = ST_XTAL;
      ST_XTAL:  if (xtal_rdy) state_d = ST_XSET;
      ST_XSET:  if (cnt_q == CNT_LAST) state_d = ST_PLL;
      ST_PLL:   if (pll_rdy)  state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
    if (state_d == ST_RUN) mode_d = MODE_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      mode_q  <= MODE_RUN;
      wfe_q   <= 1'b0;
      sev_q   <= 1'b0;
      lp_q    <= 1'b0;
      cnt_q   <= '0;
      wake_q  <= 1'b0;
      por_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      if (state_q == ST_RUN && entry_vld) begin
        wfe_q <= entry_wfe;
        sev_q <= ctl_sevonpend;
        lp_q  <= ctl_reglp;
      end
      if (state_q == ST_XSET) cnt_q <= cnt_q + 1'b1;
      else                    cnt_q <= '0;
      wake_q <= (state_d == ST_RUN) && (state_q != ST_RUN);
      por_q  <= (state_d == ST_RUN) && (state_q != ST_RUN) && (mode_q == MODE_STBY);
    end
  end

  assign cpu_clk_en  = gates.cpu_clk;
  assign core_clk_en = gates.core_clk;
  assign irc_en      = gates.irc;
  assign xtal_en     = gates.xtal;
  assign pll_en      = gates.pll;
  assign core_pwr_en = gates.pwr;
  assign reg_lowpwr  = gates.reg_lp;
  assign wake_pulse  = wake_q;
  assign por_pulse   = por_q;
  assign cur_mode    = mode_q;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_clk_en,
  input logic       core_clk_en,
  input logic       irc_en,
  input logic       xtal_en,
  input logic       pll_en,
  input logic       core_pwr_en,
  input logic       wake_pulse,
  input logic       por_pulse,
  input logic [1:0] cur_mode
);
  // R2
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'd1) |-> (!cpu_clk_en && core_clk_en));

  // R3
  clk_hier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (core_clk_en && pll_en));

  // R4
  pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_pwr_en |-> (!irc_en && !xtal_en && !pll_en && !core_clk_en));

  // R9
  osc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_en |-> xtal_en) and (xtal_en |-> irc_en));

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != 2'd0) |=> (cur_mode == $past(cur_mode) || cur_mode == 2'd0));

  // R12
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  // R12
  wake_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (cur_mode == 2'd0 && cpu_clk_en));

  // R10
  por_with_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_pulse |-> wake_pulse);
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_clk_en  (cpu_clk_en),
  .core_clk_en (core_clk_en),
  .irc_en      (irc_en),
  .xtal_en     (xtal_en),
  .pll_en      (pll_en),
  .core_pwr_en (core_pwr_en),
  .wake_pulse  (wake_pulse),
  .por_pulse   (por_pulse),
  .cur_mode    (cur_mode)
);

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
  localparam int NEXTI  = 4;
  localparam int NWKUP  = 2;
  localparam int SETTLE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic entry_vld = 0, entry_wfe = 0, ctl_deep = 0, ctl_stby = 0, ctl_wkrst = 0;
  logic ctl_sevonpend = 0, ctl_reglp = 0, irq_any = 0, evt_any = 0;
  logic [NEXTI-1:0] exti_irq = '0, exti_evt = '0;
  logic [NWKUP-1:0] wkup_pin = '0;
  logic wdog_rst = 0, rtc_alarm = 0;
  logic reg_rdy, pwr_good, irc_rdy, xtal_rdy, pll_rdy;
  logic cpu_clk_en, core_clk_en, irc_en, xtal_en, pll_en, core_pwr_en, reg_lowpwr;
  logic wake_pulse, por_pulse;
  logic [1:0] cur_mode;

  int checks = 0, failures = 0, cyc = 0;

  always #5 clk = ~clk;

  lpm_ctrl #(.NEXTI(NEXTI), .NWKUP(NWKUP), .XTAL_SETTLE(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .entry_vld(entry_vld), .entry_wfe(entry_wfe),
    .ctl_deep(ctl_deep), .ctl_stby(ctl_stby), .ctl_wkrst(ctl_wkrst),
    .ctl_sevonpend(ctl_sevonpend), .ctl_reglp(ctl_reglp),
    .irq_any(irq_any), .evt_any(evt_any), .exti_irq(exti_irq), .exti_evt(exti_evt),
    .wkup_pin(wkup_pin), .wdog_rst(wdog_rst), .rtc_alarm(rtc_alarm),
    .reg_rdy(reg_rdy), .pwr_good(pwr_good), .irc_rdy(irc_rdy),
    .xtal_rdy(xtal_rdy), .pll_rdy(pll_rdy),
    .cpu_clk_en(cpu_clk_en), .core_clk_en(core_clk_en), .irc_en(irc_en),
    .xtal_en(xtal_en), .pll_en(pll_en), .core_pwr_en(core_pwr_en),
    .reg_lowpwr(reg_lowpwr), .wake_pulse(wake_pulse), .por_pulse(por_pulse),
    .cur_mode(cur_mode)
  );

  // analog stand-ins: ready follows enable after a fixed delay
  logic [2:0] irc_d, xtal_d, pll_d, reg_d;
  logic [3:0] pwr_d;
  always @(posedge clk) begin
    if (!rst_n) begin
      irc_d <= '1; xtal_d <= '1; pll_d <= '1; reg_d <= '1; pwr_d <= '1;
    end else begin
      irc_d  <= {irc_d[1:0], irc_en};
      xtal_d <= {xtal_d[1:0], xtal_en};
      pll_d  <= {pll_d[1:0], pll_en};
      reg_d  <= {reg_d[1:0], ~reg_lowpwr};
      pwr_d  <= {pwr_d[2:0], core_pwr_en};
    end
  end
  assign irc_rdy  = irc_d[2];
  assign xtal_rdy = xtal_d[2];
  assign pll_rdy  = pll_d[2];
  assign reg_rdy  = reg_d[1];
  assign pwr_good = pwr_d[3];

  // reference model: phase 0 run, 1 sleep, 2 deep, 3 standby, 4 restoring
  localparam int K_REG = 0, K_PWR = 1, K_IRC = 2, K_XTAL = 3, K_XSET = 4, K_PLL = 5;
  int m_phase, m_mode, m_cnt;
  bit m_wfe, m_sev, m_lp, m_from_stby, m_wake, m_por;
  int steps[$];

  function automatic bit core_src_hit();
    return m_wfe ? (evt_any || (m_sev && irq_any)) : irq_any;
  endfunction
  function automatic bit line_src_hit();
    return m_wfe ? ((|exti_evt) || (m_sev && (|exti_irq))) : (|exti_irq);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_mode = 0; m_cnt = 0; m_wake = 0; m_por = 0;
      m_wfe = 0; m_sev = 0; m_lp = 0; m_from_stby = 0;
      steps.delete();
    end else begin
      m_wake = 0; m_por = 0;
      case (m_phase)
        0: if (entry_vld) begin
          m_wfe = entry_wfe; m_sev = ctl_sevonpend; m_lp = ctl_reglp;
          m_mode = !ctl_deep ? 1 : ((ctl_stby && ctl_wkrst) ? 3 : 2);
          m_phase = m_mode;
        end
        1: if (core_src_hit()) begin
          m_phase = 0; m_mode = 0; m_wake = 1;
        end
        2: if (line_src_hit()) begin
          steps.delete();
          if (m_lp) steps.push_back(K_REG);
          steps.push_back(K_IRC); steps.push_back(K_XTAL);
          steps.push_back(K_XSET); steps.push_back(K_PLL);
          m_phase = 4; m_from_stby = 0; m_cnt = 0;
        end
        3: if ((|wkup_pin) || wdog_rst || rtc_alarm) begin
          steps.delete();
          steps.push_back(K_PWR); steps.push_back(K_IRC); steps.push_back(K_XTAL);
          steps.push_back(K_XSET); steps.push_back(K_PLL);
          m_phase = 4; m_from_stby = 1; m_cnt = 0;
        end
        default: begin
          bit done;
          done = 0;
          case (steps[0])
            K_REG:  done = reg_rdy;
            K_PWR:  done = pwr_good;
            K_IRC:  done = irc_rdy;
            K_XTAL: done = xtal_rdy;
            K_XSET: begin m_cnt++; done = (m_cnt == SETTLE); end
            default: done = pll_rdy;
          endcase
          if (done) begin
            void'(steps.pop_front());
            m_cnt = 0;
            if (steps.size() == 0) begin
              m_phase = 0; m_wake = 1; m_por = m_from_stby; m_mode = 0;
            end
          end
        end
      endcase
    end
  end

  function automatic bit step_at_least(int k);
    // restoring phase: enable once the chain has reached step k
    if (m_phase != 4 || steps.size() == 0) return 0;
    if (k == K_IRC)  return steps[0] inside {K_IRC, K_XTAL, K_XSET, K_PLL};
    if (k == K_XTAL) return steps[0] inside {K_XTAL, K_XSET, K_PLL};
    return steps[0] == K_PLL;
  endfunction

  task automatic cmp(string nm, string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s cycle %0d actual=%0d expected=%0d", tag, nm, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit run_or_sleep;
      run_or_sleep = (m_phase == 0 || m_phase == 1);
      cmp("cpu_clk_en",  "R2",  {1'b0, cpu_clk_en},  {1'b0, m_phase == 0});
      cmp("core_clk_en", "R3",  {1'b0, core_clk_en}, {1'b0, run_or_sleep});
      cmp("irc_en",      "R9",  {1'b0, irc_en},  {1'b0, run_or_sleep || step_at_least(K_IRC)});
      cmp("xtal_en",     "R9",  {1'b0, xtal_en}, {1'b0, run_or_sleep || step_at_least(K_XTAL)});
      cmp("pll_en",      "R9",  {1'b0, pll_en},  {1'b0, run_or_sleep || step_at_least(K_PLL)});
      cmp("core_pwr_en", "R4",  {1'b0, core_pwr_en}, {1'b0, m_phase != 3});
      cmp("reg_lowpwr",  "R3",  {1'b0, reg_lowpwr},  {1'b0, m_phase == 2 && m_lp});
      cmp("wake_pulse",  "R12", {1'b0, wake_pulse},  {1'b0, m_wake});
      cmp("por_pulse",   "R10", {1'b0, por_pulse},   {1'b0, m_por});
      cmp("cur_mode",    "R5",  cur_mode, 2'(m_mode));
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic enter(bit wfe, bit deep, bit stby, bit wkrst, bit sev, bit lp);
    @(posedge clk); #1;
    entry_vld = 1; entry_wfe = wfe; ctl_deep = deep; ctl_stby = stby;
    ctl_wkrst = wkrst; ctl_sevonpend = sev; ctl_reglp = lp;
    @(posedge clk); #1;
    entry_vld = 0;
    @(negedge clk);
  endtask

  // 0 irq, 1 evt, 2 exti_irq, 3 exti_evt, 4 wkup, 5 wdog, 6 rtc
  task automatic pulse(int src);
    @(posedge clk); #1;
    case (src)
      0: irq_any = 1;  1: evt_any = 1;  2: exti_irq[1] = 1;  3: exti_evt[2] = 1;
      4: wkup_pin[1] = 1;  5: wdog_rst = 1;  default: rtc_alarm = 1;
    endcase
    @(posedge clk); #1;
    irq_any = 0; evt_any = 0; exti_irq = '0; exti_evt = '0;
    wkup_pin = '0; wdog_rst = 0; rtc_alarm = 0;
    @(negedge clk);
  endtask

  task automatic wait_run(string tag);
    for (int i = 0; i < 100; i++) begin
      if (cur_mode == 2'd0) break;
      @(negedge clk);
    end
    chk(tag, "back in run", cur_mode, 0);
    chk("R12", "wake pulse on first run cycle", wake_pulse, 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1", "reset mode", cur_mode, 0);
    chk("R1", "reset gates", {cpu_clk_en, core_clk_en, irc_en, xtal_en, pll_en, core_pwr_en}, 6'h3f);
    chk("R1", "reset pulses", {reg_lowpwr, wake_pulse, por_pulse}, 0);

    // R2 / R6: WFI sleep, event ignored, interrupt wakes
    enter(0, 0, 0, 0, 0, 0);
    chk("R2", "sleep mode", cur_mode, 1);
    chk("R2", "only cpu clock off", {cpu_clk_en, core_clk_en, irc_en}, 3'b011);
    pulse(1);
    chk("R6", "event ignored in WFI sleep", cur_mode, 1);
    pulse(0);
    chk("R6", "irq wakes WFI sleep", cur_mode, 0);
    chk("R12", "wake pulse", wake_pulse, 1);
    @(negedge clk);
    chk("R12", "wake pulse single cycle", wake_pulse, 0);

    // R6: WFE without sevonpend
    enter(1, 0, 0, 0, 0, 0);
    pulse(0);
    chk("R6", "irq ignored in WFE sleep", cur_mode, 1);
    pulse(1);
    chk("R6", "event wakes WFE sleep", cur_mode, 0);

    // R6: WFE with sevonpend
    enter(1, 0, 0, 0, 1, 0);
    pulse(0);
    chk("R6", "pending irq wakes with sevonpend", cur_mode, 0);

    // R11: second strobe during sleep ignored
    enter(0, 0, 0, 0, 0, 0);
    enter(0, 1, 1, 1, 0, 0);
    chk("R11", "entry ignored in sleep", cur_mode, 1);
    chk("R11", "core clock kept", core_clk_en, 1);
    pulse(0);
    chk("R6", "wake after ignored entry", cur_mode, 0);

    // R3 / R5 / R7 / R9: deep sleep, regulator low power
    enter(0, 1, 0, 0, 0, 1);
    chk("R3", "deep mode", cur_mode, 2);
    chk("R3", "deep gates off", {core_clk_en, irc_en, xtal_en, pll_en, core_pwr_en}, 5'b00001);
    chk("R3", "regulator low power", reg_lowpwr, 1);
    #1; ctl_deep = 0; ctl_stby = 1; ctl_wkrst = 1; entry_wfe = 1; ctl_sevonpend = 1;
    repeat (2) @(negedge clk);
    chk("R5", "mode unchanged after control writes", cur_mode, 2);
    pulse(0); pulse(1); pulse(3); pulse(4);
    chk("R7", "core sources ignored in deep", cur_mode, 2);
    pulse(2);
    chk("R9", "regulator step before oscillator", {irc_en, reg_lowpwr}, 2'b00);
    wait_run("R9");
    chk("R10", "no power-on flag after deep", por_pulse, 0);

    // R3 / R7: stby set but wakeup-reset flag clear falls to deep
    enter(1, 1, 1, 0, 1, 0);
    chk("R3", "stby without flag is deep", cur_mode, 2);
    pulse(2);
    chk("R9", "oscillator first without regulator step", irc_en, 1);
    wait_run("R7");

    // R7: WFE deep without sevonpend
    enter(1, 1, 0, 0, 0, 0);
    pulse(2);
    chk("R7", "line irq ignored in WFE deep", cur_mode, 2);
    pulse(3);
    wait_run("R7");

    // R4 / R8 / R10: standby, woken by pin, rtc, watchdog
    for (int s = 4; s <= 6; s++) begin
      enter(0, 1, 1, 1, 1, 0);
      chk("R4", "standby mode", cur_mode, 3);
      chk("R4", "core power off", core_pwr_en, 0);
      pulse(0); pulse(2); pulse(3);
      chk("R8", "other sources ignored in standby", cur_mode, 3);
      pulse(s);
      chk("R10", "power before oscillator", {core_pwr_en, irc_en}, 2'b10);
      wait_run("R8");
      chk("R10", "power-on flag", por_pulse, 1);
    end

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule